// File: doc/BRIEF.md
# Cross-Width Bus Exchange Register

This block is a 48-bit holding register that moves values between a 48-bit wide
program-data path and a 40-bit narrow path. The narrow path serves both the data
bus and the register file. The register is made of two parts: a 32-bit upper
part at bits 47:16 and a 16-bit lower part at bits 15:0. Each transfer selects
the lower part, the upper part or both. It also selects the path, the direction
(load into the register or drive out of it) and whether the far side is internal
or external memory.

Loads take effect at the rising clock edge. Driven values are combinational from
the stored contents and the current selects. Every path has fixed lane positions
and zero padding. A whole-register drive toward external memory is refused: it is
flagged, and nothing is driven. Instruction decode, memories and bus arbitration
are outside this block.

Top module: `xreg_exchange`

## Requirements
- R1: Synchronous active-high reset clears both parts to zero. A whole-register drive on the wide path after reset reads 0.
- R2: Whole-register transfers on the wide path move all 48 bits. The upper part sits on bus bits 47:16 and the lower part on bits 15:0.
- R3: A part-only drive on the wide path zero-pads the rest of the bus. The upper part goes to bits 47:16 with bits 15:0 zero. The lower part goes to bits 15:0 with bits 47:16 zero. Part-only loads on the wide path take the same lanes.
- R4: Upper-part transfers on the narrow path use narrow bits 39:8. On a drive, bits 7:0 are zero.
- R5: Lower-part transfers on the narrow path use narrow bits 23:8. On a drive, bits 39:24 and 7:0 are zero.
- R6: Internal whole-register transfers on the narrow path use register bits 47:8. The same holds for register-file transfers, where the external flag is ignored. A drive outputs register bits 47:8. A load fills register bits 47:8 from the bus and clears register bits 7:0.
- R7: An external whole-register load on the data-bus path (path code 1) loads all 48 bits from the wide input.
- R8: A whole-register drive with the external flag set on the wide or data-bus path sets `illegal_req` in the same cycle. Both outputs stay zero and the register is unchanged.
- R9: Loading one part leaves the other part unchanged. A whole load updates both parts at the same edge.
- R10: Both outputs are zero when `xfer_en` is low or when loading. Target code 3 and path code 3 neither load nor drive.

Encodings:
- Target: 0 = lower, 1 = upper, 2 = whole.
- Path: 0 = wide, 1 = data bus, 2 = register file.
- `load_dir`: 1 = load, 0 = drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer request this cycle |
| tgt_sel | input | 2 | Part select: 0 lower, 1 upper, 2 whole, 3 none |
| path_sel | input | 2 | Path: 0 wide, 1 data bus, 2 register file, 3 none |
| load_dir | input | 1 | 1 load into register, 0 drive out |
| ext_mem | input | 1 | Far side is external memory |
| wide_in | input | 48 | Wide path input lanes |
| narrow_in | input | 40 | Narrow path input lanes |
| wide_out | output | 48 | Wide path driven value |
| narrow_out | output | 40 | Narrow path driven value |
| illegal_req | output | 1 | Refused whole-register external drive |

## Verification
Driven values and the illegal flag are due in the same cycle as the request. A load becomes visible only after the next rising edge. The driver therefore applies each request just after a rising edge, and the monitor compares at the following falling edge. The result of every load is checked by a separate drive request in a later cycle, which reads the register back through the normal outputs.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    parameter int LO_W     = 16;
    parameter int HI_W     = 32;
    parameter int WIDE_W   = LO_W + HI_W;
    parameter int NARROW_W = 40;
    parameter int PAD_W    = WIDE_W - NARROW_W;
    parameter int TOPZ_W   = NARROW_W - PAD_W - LO_W;

    typedef enum logic [1:0] {
        TGT_LOW   = 2'd0,
        TGT_HIGH  = 2'd1,
        TGT_WHOLE = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        PATH_WIDE = 2'd0,
        PATH_DATA = 2'd1,
        PATH_RF   = 2'd2,
        PATH_NONE = 2'd3
    } path_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } xreg_t;

    typedef struct packed {
        logic            we_hi;
        logic            we_lo;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } xload_t;

    function automatic logic is_narrow(path_e p);
        return (p == PATH_DATA) || (p == PATH_RF);
    endfunction
endpackage

// File: rtl/xreg_in_align.sv
module xreg_in_align
    import xreg_pkg::*;
(
    input  logic                req,
    input  tgt_e                tgt,
    input  path_e               path,
    input  logic                load,
    input  logic                ext,
    input  logic [WIDE_W-1:0]   wide_in,
    input  logic [NARROW_W-1:0] narrow_in,
    output xload_t              ld
);
    always_comb begin
        ld = '0;
        if (req && load) begin
            if (path == PATH_WIDE) begin
                case (tgt)
                    TGT_LOW: begin
                        ld.we_lo = 1'b1;
                        ld.lo    = wide_in[LO_W-1:0];
                    end
                    TGT_HIGH: begin
                        ld.we_hi = 1'b1;
                        ld.hi    = wide_in[WIDE_W-1:LO_W];
                    end
                    TGT_WHOLE: begin
                        ld.we_hi = 1'b1;
                        ld.we_lo = 1'b1;
                        {ld.hi, ld.lo} = wide_in;
                    end
                    default: ld = '0;
                endcase
            end else if (is_narrow(path)) begin
                case (tgt)
                    TGT_LOW: begin
                        ld.we_lo = 1'b1;
                        ld.lo    = narrow_in[PAD_W+LO_W-1:PAD_W];
                    end
                    TGT_HIGH: begin
                        ld.we_hi = 1'b1;
                        ld.hi    = narrow_in[NARROW_W-1:PAD_W];
                    end
                    TGT_WHOLE: begin
                        ld.we_hi = 1'b1;
                        ld.we_lo = 1'b1;
                        if (path == PATH_DATA && ext)
                            {ld.hi, ld.lo} = wide_in;
                        else
                            {ld.hi, ld.lo} = {narrow_in, {PAD_W{1'b0}}};
                    end
                    default: ld = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/xreg_store.sv
module xreg_store
    import xreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xload_t ld,
    output xreg_t  cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (ld.we_hi) cur.hi <= ld.hi;
            if (ld.we_lo) cur.lo <= ld.lo;
        end
    end
endmodule

// File: rtl/xreg_out_align.sv
module xreg_out_align
    import xreg_pkg::*;
(
    input  logic                req,
    input  tgt_e                tgt,
    input  path_e               path,
    input  logic                load,
    input  logic                ext,
    input  xreg_t               cur,
    output logic [WIDE_W-1:0]   wide_out,
    output logic [NARROW_W-1:0] narrow_out,
    output logic                illegal
);
    logic drive;

    assign illegal = req && !load && (tgt == TGT_WHOLE) && ext &&
                     ((path == PATH_WIDE) || (path == PATH_DATA));
    assign drive   = req && !load && !illegal;

    always_comb begin
        wide_out   = '0;
        narrow_out = '0;
        if (drive) begin
            if (path == PATH_WIDE) begin
                case (tgt)
                    TGT_LOW:   wide_out = {{HI_W{1'b0}}, cur.lo};
                    TGT_HIGH:  wide_out = {cur.hi, {LO_W{1'b0}}};
                    TGT_WHOLE: wide_out = cur;
                    default:   wide_out = '0;
                endcase
            end else if (is_narrow(path)) begin
                case (tgt)
                    TGT_LOW:   narrow_out = {{TOPZ_W{1'b0}}, cur.lo, {PAD_W{1'b0}}};
                    TGT_HIGH:  narrow_out = {cur.hi, {PAD_W{1'b0}}};
                    TGT_WHOLE: narrow_out = cur[WIDE_W-1:PAD_W];
                    default:   narrow_out = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/xreg_exchange.sv
module xreg_exchange
    import xreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer_en,
    input  logic [1:0]          tgt_sel,
    input  logic [1:0]          path_sel,
    input  logic                load_dir,
    input  logic                ext_mem,
    input  logic [WIDE_W-1:0]   wide_in,
    input  logic [NARROW_W-1:0] narrow_in,
    output logic [WIDE_W-1:0]   wide_out,
    output logic [NARROW_W-1:0] narrow_out,
    output logic                illegal_req
);
    tgt_e   tgt;
    path_e  path;
    xload_t ld;
    xreg_t  cur_q;

    assign tgt  = tgt_e'(tgt_sel);
    assign path = path_e'(path_sel);

    xreg_in_align u_in (
        .req       (xfer_en),
        .tgt       (tgt),
        .path      (path),
        .load      (load_dir),
        .ext       (ext_mem),
        .wide_in   (wide_in),
        .narrow_in (narrow_in),
        .ld        (ld)
    );

    xreg_store u_store (
        .clk (clk),
        .rst (rst),
        .ld  (ld),
        .cur (cur_q)
    );

    xreg_out_align u_out (
        .req        (xfer_en),
        .tgt        (tgt),
        .path       (path),
        .load       (load_dir),
        .ext        (ext_mem),
        .cur        (cur_q),
        .wide_out   (wide_out),
        .narrow_out (narrow_out),
        .illegal    (illegal_req)
    );
endmodule

// File: rtl/xreg_exchange_chk.sv
module xreg_exchange_chk
    import xreg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                xfer_en,
    input logic [1:0]          tgt_sel,
    input logic [1:0]          path_sel,
    input logic                load_dir,
    input logic [WIDE_W-1:0]   wide_in,
    input logic [WIDE_W-1:0]   wide_out,
    input logic [NARROW_W-1:0] narrow_out,
    input logic                illegal_req,
    input xreg_t               cur
);
    logic drv_narrow;
    assign drv_narrow = xfer_en && !load_dir && (path_sel == 2'd1 || path_sel == 2'd2);

    AST_UPPER_LOAD_KEEPS_LOWER: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && load_dir && tgt_sel == 2'd1) |=> (cur.lo == $past(cur.lo))); // R9
    AST_LOWER_LOAD_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && load_dir && tgt_sel == 2'd0) |=> (cur.hi == $past(cur.hi))); // R9
    AST_WIDE_WHOLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && load_dir && tgt_sel == 2'd2 && path_sel == 2'd0) |=> (cur == $past(wide_in))); // R2
    AST_REFUSED_IS_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal_req |-> (wide_out == '0 && narrow_out == '0)); // R8
    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!xfer_en || load_dir) |-> (wide_out == '0 && narrow_out == '0)); // R10
    AST_NARROW_LOWER_PAD: assert property (@(posedge clk) disable iff (rst)
        (drv_narrow && tgt_sel == 2'd0) |-> (narrow_out[39:24] == '0 && narrow_out[7:0] == '0)); // R5
    AST_NARROW_UPPER_LANE: assert property (@(posedge clk) disable iff (rst)
        (drv_narrow && tgt_sel == 2'd1) |-> (narrow_out == {cur.hi, 8'h00})); // R4
endmodule

bind xreg_exchange xreg_exchange_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .xfer_en     (xfer_en),
    .tgt_sel     (tgt_sel),
    .path_sel    (path_sel),
    .load_dir    (load_dir),
    .wide_in     (wide_in),
    .wide_out    (wide_out),
    .narrow_out  (narrow_out),
    .illegal_req (illegal_req),
    .cur         (cur_q)
);

// File: tb/xreg_exchange_tb.sv
`timescale 1ns/1ps
module xreg_exchange_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_en = 1'b0;
    logic [1:0]  tgt_sel = 2'd0;
    logic [1:0]  path_sel = 2'd0;
    logic        load_dir = 1'b0;
    logic        ext_mem = 1'b0;
    logic [47:0] wide_in = '0;
    logic [39:0] narrow_in = '0;
    logic [47:0] wide_out;
    logic [39:0] narrow_out;
    logic        illegal_req;

    always #2 clk = ~clk;

    xreg_exchange u_dut (
        .clk(clk), .rst(rst), .xfer_en(xfer_en), .tgt_sel(tgt_sel),
        .path_sel(path_sel), .load_dir(load_dir), .ext_mem(ext_mem),
        .wide_in(wide_in), .narrow_in(narrow_in), .wide_out(wide_out),
        .narrow_out(narrow_out), .illegal_req(illegal_req)
    );

    typedef struct {
        logic [47:0] w;
        logic [39:0] n;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [47:0] model = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    task automatic op(input logic en, input logic [1:0] t, input logic [1:0] p,
                      input logic ld, input logic ext, input logic [47:0] wi,
                      input logic [39:0] ni, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        xfer_en = en; tgt_sel = t; path_sel = p; load_dir = ld;
        ext_mem = ext; wide_in = wi; narrow_in = ni;
        e.w = '0; e.n = '0; e.tag = tag;
        e.ill = en && !ld && t == 2'd2 && ext && (p == 2'd0 || p == 2'd1);
        if (en && !ld && !e.ill) begin
            if (p == 2'd0) begin
                if (t == 2'd0) e.w = {32'h0, model[15:0]};
                else if (t == 2'd1) e.w = {model[47:16], 16'h0};
                else if (t == 2'd2) e.w = model;
            end else if (p == 2'd1 || p == 2'd2) begin
                if (t == 2'd0) e.n = {16'h0, model[15:0], 8'h0};
                else if (t == 2'd1) e.n = {model[47:16], 8'h0};
                else if (t == 2'd2) e.n = model[47:8];
            end
        end
        sbq.push_back(e);
        if (en && ld) begin
            if (p == 2'd0) begin
                if (t == 2'd0) model[15:0] = wi[15:0];
                else if (t == 2'd1) model[47:16] = wi[47:16];
                else if (t == 2'd2) model = wi;
            end else if (p == 2'd1 || p == 2'd2) begin
                if (t == 2'd0) model[15:0] = ni[23:8];
                else if (t == 2'd1) model[47:16] = ni[39:8];
                else if (t == 2'd2) model = (p == 2'd1 && ext) ? wi : {ni, 8'h0};
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (wide_out !== e.w || narrow_out !== e.n || illegal_req !== e.ill) begin
                errors++;
                $display("FAIL %s: wide=%h narrow=%h illegal=%b expected wide=%h narrow=%h illegal=%b",
                         e.tag, wide_out, narrow_out, illegal_req, e.w, e.n, e.ill);
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        op(1, 2, 0, 0, 0, '0, '0, "R1 reset clears register");
        op(1, 2, 0, 1, 0, 48'h123456789ABC, '0, "R10 load drives nothing");
        op(1, 2, 0, 0, 0, '0, '0, "R2 wide whole readback");
        op(1, 1, 0, 0, 0, '0, '0, "R3 wide upper drive");
        op(1, 0, 0, 0, 0, '0, '0, "R3 wide lower drive");
        op(1, 0, 0, 1, 0, 48'hFFFFFFFF5A5A, '0, "R3 wide lower load");
        op(1, 2, 0, 0, 0, '0, '0, "R9 lower load keeps upper");
        op(1, 1, 1, 1, 0, '0, 40'hCAFEBABE77, "R4 narrow upper load");
        op(1, 2, 0, 0, 0, '0, '0, "R9 upper load keeps lower");
        op(1, 1, 1, 0, 0, '0, '0, "R4 narrow upper drive");
        op(1, 0, 2, 1, 0, '0, 40'h1122334455, "R5 narrow lower load");
        op(1, 2, 0, 0, 0, '0, '0, "R5 lower lane readback");
        op(1, 0, 1, 0, 0, '0, '0, "R5 narrow lower drive");
        op(1, 2, 1, 1, 0, 48'hFFFFFFFFFFFF, 40'hA1B2C3D4E5, "R6 narrow whole load");
        op(1, 2, 0, 0, 0, '0, '0, "R6 low byte cleared");
        op(1, 2, 1, 0, 0, '0, '0, "R6 narrow whole drive");
        op(1, 2, 2, 1, 1, 48'hFFFFFFFFFFFF, 40'h0102030405, "R6 register file ignores external");
        op(1, 2, 2, 0, 1, '0, '0, "R6 register file external drive");
        op(1, 2, 1, 1, 1, 48'hFEDCBA987654, 40'h0, "R7 external whole load");
        op(1, 2, 0, 0, 0, '0, '0, "R7 readback");
        op(1, 2, 0, 0, 1, '0, '0, "R8 wide external whole refused");
        op(1, 2, 1, 0, 1, '0, '0, "R8 data external whole refused");
        op(1, 2, 0, 0, 0, '0, '0, "R8 register unchanged");
        op(1, 1, 0, 0, 1, '0, '0, "R8 external upper drive allowed");
        op(0, 2, 0, 0, 0, '0, '0, "R10 no request");
        op(1, 3, 0, 1, 0, 48'h111111111111, '0, "R10 reserved target load");
        op(1, 2, 3, 1, 0, 48'h222222222222, 40'h3333333333, "R10 reserved path load");
        op(1, 2, 3, 0, 0, '0, '0, "R10 reserved path drive");
        op(1, 2, 0, 0, 0, '0, '0, "R10 register unchanged");
        op(0, 0, 0, 0, 0, '0, '0, "R10 idle");
        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule